// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register

This block turns a parallel word into a serial bit stream. It has eight stages by default, one parallel input bit for each stage, and a serial input that feeds the first stage. Each shift moves the contents one stage toward the last stage. The last stage is driven out in both true and inverted form. An active-low load control copies the parallel word into all stages. While the load control is low, it overrides every other input.

The block runs on a fast system clock. Two external control pins, a shift clock pin and an inhibit pin, are treated as a pair. Their OR forms the effective stage clock, so either pin can advance the register, but only while the other pin is low. Both pins pass through a synchroniser. A rising edge of their OR, as seen on the system clock, produces a single one-cycle shift strobe. The load control, the serial input and the parallel inputs are sampled directly on the system clock.

Top module: `psr_piso`

## Requirements
- R1: A synchronous active-low reset clears every stage to 0. The edge history is set to the current pin level, so a pin that is already high when reset is released causes no shift.
- R2: While load_n is 0, every stage takes its parallel bit on the next system clock: bit 0 goes to the first stage (the serial-input end) and bit WIDTH-1 goes to the last stage. The levels of clk_pin, inh_pin and ser_in have no effect on the load.
- R3: When load_n is low and a pin rising edge occurs in the same cycle, the load wins and no shift takes place.
- R4: With load_n high and inh_pin low, a 0-to-1 change on clk_pin shifts the register by exactly one stage toward the output, and ser_in enters the first stage. The shift is visible on the outputs within three system clocks after the pin change.
- R5: With load_n high and clk_pin low, a 0-to-1 change on inh_pin also shifts the register by exactly one stage.
- R6: While either pin is held high, edges on the other pin cause no shift.
- R7: q_out equals the last stage and q_out_n equals its complement.
- R8: With load_n high and no qualifying rising edge, every stage keeps its value, including when a pin falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_n | input | 1 | Active-low parallel load, level sensitive |
| clk_pin | input | 1 | Asynchronous shift clock pin |
| inh_pin | input | 1 | Asynchronous inhibit pin, interchangeable with clk_pin |
| ser_in | input | 1 | Serial data into the first stage |
| par_in | input | WIDTH | Parallel word; bit 0 is the first stage |
| q_out | output | 1 | Last stage |
| q_out_n | output | 1 | Complement of the last stage |

## Verification
The assertions assume that load_n, ser_in and par_in are synchronous to sys_clk. They also assume that the pins stay steady long enough for the synchroniser to settle, so that one pin transition produces at most one shift strobe. The stimulus changes every input on the falling edge of the system clock. After each pin change it waits four system cycles before it moves on or samples the outputs, and it holds load_n low for several cycles so that the load spans any edge window it overlaps.

// File: rtl/psr_pkg.sv
package psr_pkg;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_SHIFT = 2'd2
  } psr_op_e;

  // Load has priority over a shift strobe in the same cycle.
  function automatic psr_op_e pick_op(input logic load_n, input logic rise);
    if (!load_n)   return OP_LOAD;
    else if (rise) return OP_SHIFT;
    else           return OP_HOLD;
  endfunction

endpackage

// File: rtl/psr_sync.sv
module psr_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) chain[0] <= d;

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) chain[s] <= chain[s-1];
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/psr_edge.sv
module psr_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_a,
  input  logic pin_b,
  output logic gated,
  output logic rise
);

  logic hist;

  assign gated = pin_a | pin_b;

  // During reset the history follows the live level, so a pin that is
  // already high when reset is released gives no strobe.
  always_ff @(posedge clk) begin
    if (!rst_n) hist <= gated;
    else        hist <= gated;
  end

  assign rise = rst_n & gated & ~hist;

  // R4: one pin transition yields a strobe of a single cycle
  p_single_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/psr_stages.sv
module psr_stages
  import psr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_n,
  input  logic             rise,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  output logic             last_q
);

  localparam int LAST = WIDTH - 1;

  logic [WIDTH-1:0] st;
  psr_op_e          op;

  function automatic logic [WIDTH-1:0] step(input logic [WIDTH-1:0] s,
                                            input logic b);
    return {s[LAST-1:0], b};
  endfunction

  always_comb op = pick_op(load_n, rise);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= '0;
    end else begin
      case (op)
        OP_LOAD:  st <= par_in;
        OP_SHIFT: st <= step(st, ser_in);
        default:  st <= st;
      endcase
    end
  end

  assign last_q = st[LAST];

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> st == '0);

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |=> st == $past(par_in));

  p_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && rise) |=> st == {$past(st[LAST-1:0]), $past(ser_in)});

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && !rise) |=> $stable(st));

endmodule

// File: rtl/psr_piso.sv
module psr_piso #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             sys_clk,
  input  logic             rst_n,
  input  logic             load_n,
  input  logic             clk_pin,
  input  logic             inh_pin,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  output logic             q_out,
  output logic             q_out_n
);

  logic [1:0] pins_sync;
  logic       gated_clk;
  logic       shift_rise;
  logic       last_q;

  psr_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (sys_clk),
    .d   ({inh_pin, clk_pin}),
    .q   (pins_sync)
  );

  psr_edge u_edge (
    .clk   (sys_clk),
    .rst_n (rst_n),
    .pin_a (pins_sync[0]),
    .pin_b (pins_sync[1]),
    .gated (gated_clk),
    .rise  (shift_rise)
  );

  psr_stages #(.WIDTH(WIDTH)) u_stages (
    .clk    (sys_clk),
    .rst_n  (rst_n),
    .load_n (load_n),
    .rise   (shift_rise),
    .ser_in (ser_in),
    .par_in (par_in),
    .last_q (last_q)
  );

  assign q_out   = last_q;
  assign q_out_n = ~last_q;

  // R6: no strobe while the gated clock was already high
  p_blocked_r6: assert property (@(posedge sys_clk) disable iff (!rst_n)
    $past(gated_clk) |-> !shift_rise);

endmodule

// File: tb/tb_psr_piso.sv
module tb_psr_piso;

  localparam int W = 8;

  logic         sys_clk = 1'b0;
  logic         rst_n   = 1'b0;
  logic         load_n  = 1'b1;
  logic         clk_pin = 1'b0;
  logic         inh_pin = 1'b0;
  logic         ser_in  = 1'b0;
  logic [W-1:0] par_in  = '0;
  logic         q_out;
  logic         q_out_n;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [W-1:0] mdl     = '0;
  logic         prev_or = 1'b0;

  logic  exp_q[$];
  string exp_tag[$];

  always #4 sys_clk = ~sys_clk;

  psr_piso #(.WIDTH(W)) dut (
    .sys_clk (sys_clk),
    .rst_n   (rst_n),
    .load_n  (load_n),
    .clk_pin (clk_pin),
    .inh_pin (inh_pin),
    .ser_in  (ser_in),
    .par_in  (par_in),
    .q_out   (q_out),
    .q_out_n (q_out_n)
  );

  // monitor: pops expected items and compares them with the outputs
  always @(negedge sys_clk) begin
    while (exp_q.size() > 0) begin
      logic  e;
      string t;
      e = exp_q.pop_front();
      t = exp_tag.pop_front();
      n_checks++;
      if (q_out !== e || q_out_n !== ~e) begin
        n_fail++;
        $display("FAIL %s: q_out=%b q_out_n=%b expected %b/%b", t, q_out, q_out_n, e, ~e);
      end
    end
  end

  task automatic push(input string tag);
    exp_q.push_back(mdl[W-1]);
    exp_tag.push_back(tag);
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge sys_clk);
  endtask

  // drive both pins; the model shifts on a 0->1 change of their OR
  task automatic set_pins(input logic c, input logic i, input logic s, input string tag);
    logic now_or;
    now_or  = c | i;
    ser_in  = s;
    clk_pin = c;
    inh_pin = i;
    if (now_or && !prev_or) mdl = {mdl[W-2:0], s};
    prev_or = now_or;
    settle(4);
    push(tag);
    settle(1);
  endtask

  task automatic load(input logic [W-1:0] v, input logic c, input logic i,
                      input logic s, input string tag);
    par_in  = v;
    load_n  = 1'b0;
    ser_in  = s;
    clk_pin = c;
    inh_pin = i;
    settle(5);
    load_n  = 1'b1;
    mdl     = v;
    prev_or = c | i;
    settle(1);
    push(tag);
    settle(1);
  endtask

  // one clk_pin pulse (inhibit low), checking after the rise
  task automatic clk_pulse(input logic s, input string tag);
    set_pins(1'b1, 1'b0, s, tag);
    set_pins(1'b0, 1'b0, s, tag);
  endtask

  task automatic inh_pulse(input logic s, input string tag);
    set_pins(1'b0, 1'b1, s, tag);
    set_pins(1'b0, 1'b0, s, tag);
  endtask

  initial begin
    settle(1);
    #(8 * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state, R7: output polarity
    settle(4);
    rst_n = 1'b1;
    settle(2);
    push("R1 reset state / R7");
    settle(1);

    // R2 load with pins low, then R4 clocked shifts through all stages
    load(8'hA5, 1'b0, 1'b0, 1'b0, "R2 load A5");
    for (int k = 0; k < W; k++) clk_pulse(k[0] ^ k[1], "R4 clk shift");

    // R2 load while clk_pin high and ser_in high
    load(8'h5A, 1'b1, 1'b0, 1'b1, "R2 load under clk high");
    set_pins(1'b0, 1'b0, 1'b1, "R8 clk falls, hold");
    // R5 inhibit-driven shifting with clk low
    for (int k = 0; k < W; k++) inh_pulse(k[0], "R5 inh shift");

    // R6 blocking in both directions
    load(8'h0F, 1'b0, 1'b0, 1'b0, "R2 load 0F");
    set_pins(1'b0, 1'b1, 1'b1, "R5 inh rise shifts");
    for (int k = 0; k < 3; k++) begin
      set_pins(1'b1, 1'b1, 1'b0, "R6 clk blocked by inh");
      set_pins(1'b0, 1'b1, 1'b0, "R6 clk blocked by inh");
    end
    set_pins(1'b0, 1'b0, 1'b0, "R8 inh falls, hold");
    set_pins(1'b1, 1'b0, 1'b1, "R4 clk rise shifts");
    for (int k = 0; k < 3; k++) begin
      set_pins(1'b1, 1'b1, 1'b0, "R6 inh blocked by clk");
      set_pins(1'b1, 1'b0, 1'b0, "R6 inh blocked by clk");
    end
    set_pins(1'b0, 1'b0, 1'b0, "R8 clk falls, hold");
    for (int k = 0; k < W; k++) clk_pulse(1'b0, "R6 contents after blocking");
    settle(10);
    push("R8 idle hold");
    settle(1);

    // R3 load overlapping a clk_pin rise: load wins
    load(8'hC3, 1'b1, 1'b0, 1'b0, "R3 load beats edge");
    set_pins(1'b0, 1'b0, 1'b0, "R3 no shift after release");
    for (int k = 0; k < W; k++) clk_pulse(1'b1, "R3 contents intact");

    // R1 reset with clk_pin high: no shift when released
    load(8'hFF, 1'b0, 1'b0, 1'b1, "R2 load FF");
    rst_n   = 1'b0;
    ser_in  = 1'b1;
    clk_pin = 1'b1;
    settle(5);
    rst_n   = 1'b1;
    mdl     = '0;
    prev_or = 1'b1;
    settle(5);
    push("R1 reset clears, pin high");
    settle(1);
    set_pins(1'b0, 1'b0, 1'b0, "R1 no spurious shift");
    for (int k = 0; k < W - 1; k++) clk_pulse(1'b0, "R1 no spurious shift");

    settle(4);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule